// File: doc/BRIEF.md
# Conversion Readout Sequencer

This block is a synchronous host-side master that runs one full conversion-and-readout exchange with an external serial converter. After a single-cycle start request it drives the active-low convert-start line (`conv_n`) low. It then watches the returned data line. The line reads low while the converter is busy, and a low-to-high transition on it means the data is ready. Once that transition arrives, the block issues sixteen serial clock pulses on `sclk`. The widths of the high and low phases are set by parameters counted in system clocks.

Each bit is taken from the synchronised data line in the last system clock of a high phase. The first captured bit is a ready marker that must read 1. The other fifteen bits make up the result, most significant bit first. One cycle after the sixteenth falling edge, the block raises `conv_n`, clears `busy` and pulses either `res_valid` or `marker_err`.

If no ready transition appears within a parameterised number of clocks, the block gives up. It pulses `timeout_err` and returns `conv_n` high without issuing any clock.

Top module: `adc_readout_master`

## Requirements
- R1: After reset, `conv_n` is 1, `sclk` is 0, `busy` is 0, `res_valid`, `marker_err` and `timeout_err` are 0, and `res_data` is 0.
- R2: A start request is accepted only while `busy` is 0. One clock after the accepted request, `conv_n` is 0 and `busy` is 1. A request made while `busy` is 1 has no effect: the running exchange completes normally and no new exchange follows it.
- R3: `sclk` is 0 whenever `conv_n` is 1. No `sclk` rising edge occurs before the data line has shown a low-to-high transition, as seen through a two-flop synchroniser, after `conv_n` fell.
- R4: A completed exchange has exactly 16 `sclk` pulses. Each high phase lasts HI_W clocks, and each low phase between pulses lasts LO_W clocks.
- R5: The data line is sampled through the synchroniser in the last clock of each high phase, which requires HI_W+LO_W >= 3. The first sample is the marker. The following 15 samples fill `res_data` from bit 14 down to bit 0.
- R6: One clock after the 16th falling edge of `sclk`, `conv_n` returns to 1 and `busy` falls. In that same cycle `res_valid` is 1 for one clock and `res_data` carries the new 15-bit result.
- R7: If the marker sample is 0, `marker_err` pulses instead of `res_valid`, and `res_data` keeps its previous value.
- R8: If no ready transition is detected within TMO clocks of `conv_n` falling, `conv_n` returns to 1 after exactly TMO clocks low. `busy` falls and `timeout_err` pulses at the same time, and no `sclk` pulse is issued. A transition detected in the last clock of the window still counts as ready.
- R9: `res_valid`, `marker_err` and `timeout_err` are one-clock pulses. At most one of them is 1 at any time, and each is only raised as `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin an exchange, sampled each clock |
| sdat_in | input | 1 | Serial data and ready line from the converter |
| conv_n | output | 1 | Active-low convert-start to the converter |
| sclk | output | 1 | Serial clock to the converter, idles low |
| busy | output | 1 | High from acceptance until the exchange closes |
| res_data | output | 15 | Last valid conversion result |
| res_valid | output | 1 | One-clock pulse: new result with a good marker |
| marker_err | output | 1 | One-clock pulse: marker bit read as 0 |
| timeout_err | output | 1 | One-clock pulse: ready transition never arrived |

## Verification
Two functions can collide in one cycle: the ready transition reaching the state machine, and the ready-wait timer expiring. The bench delays the ready rise so that the synchronised edge lands exactly in the last clock of the TMO window, where ready must win and a normal result must follow. It then moves the rise one clock later, where the exchange must close on timeout after exactly TMO clocks with no clock pulse. Random results, marker failures and ready delays are mixed around these two directed cases, and every outcome is compared with bench-computed values.

// File: rtl/rdout_pkg.sv
package rdout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LO,
        ST_HI,
        ST_DONE
    } rd_state_e;

    typedef struct packed {
        logic conv_n;
        logic sclk;
        logic busy;
    } pins_t;

    typedef struct packed {
        logic ok;
        logic bad_marker;
        logic timeout;
    } evt_t;

    // bits needed to hold the value v (at least one)
    function automatic int cnt_w(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdout_insync.sv
module rdout_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/rdout_dncnt.sv
module rdout_dncnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // final clock of the loaded window
    assign last = (cnt == W'(1));
endmodule

// File: rtl/rdout_shreg.sv
module rdout_shreg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [N-1:0] word,
    output logic         at_last
);
    localparam int CW = $clog2(N);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
            cnt  <= '0;
        end else if (en) begin
            word <= {word[N-2:0], din};
            cnt  <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == CW'(N - 1));
endmodule

// File: rtl/adc_readout_master.sv
module adc_readout_master
    import rdout_pkg::*;
#(
    parameter int HI_W        = 2,
    parameter int LO_W        = 2,
    parameter int TMO         = 64,
    parameter int NBITS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             sdat_in,
    output logic             conv_n,
    output logic             sclk,
    output logic             busy,
    output logic [NBITS-2:0] res_data,
    output logic             res_valid,
    output logic             marker_err,
    output logic             timeout_err
);
    localparam int RW = NBITS - 1;
    localparam int PW = cnt_w(max2(HI_W, LO_W));
    localparam int TW = cnt_w(TMO);

    rd_state_e       st;
    pins_t           pins;
    evt_t            evt;
    logic [RW-1:0]   res_q;

    logic            d_lvl, d_rise;
    logic            ph_load, ph_last;
    logic [PW-1:0]   ph_val;
    logic            rt_load, rt_last;
    logic            sh_clr, sh_en, sh_last;
    logic [NBITS-1:0] sh_word;

    rdout_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sdat_in),
        .lvl (d_lvl),
        .rise(d_rise)
    );

    rdout_dncnt #(.W(PW)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .load  (ph_load),
        .ld_val(ph_val),
        .last  (ph_last)
    );

    rdout_dncnt #(.W(TW)) u_rdy_tmr (
        .clk   (clk),
        .rst   (rst),
        .load  (rt_load),
        .ld_val(TW'(TMO)),
        .last  (rt_last)
    );

    rdout_shreg #(.N(NBITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (sh_clr),
        .en     (sh_en),
        .din    (d_lvl),
        .word   (sh_word),
        .at_last(sh_last)
    );

    // timer loads and shift strobes
    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        rt_load = 1'b0;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_req) begin
                    rt_load = 1'b1;
                    sh_clr  = 1'b1;
                end
            end
            ST_WAIT: begin
                if (d_rise) begin
                    ph_load = 1'b1;
                    ph_val  = PW'(LO_W);
                end
            end
            ST_LO: begin
                if (ph_last) begin
                    ph_load = 1'b1;
                    ph_val  = PW'(HI_W);
                end
            end
            ST_HI: begin
                if (ph_last) begin
                    sh_en = 1'b1;
                    if (!sh_last) begin
                        ph_load = 1'b1;
                        ph_val  = PW'(LO_W);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            pins  <= '{conv_n: 1'b1, sclk: 1'b0, busy: 1'b0};
            evt   <= '0;
            res_q <= '0;
        end else begin
            evt <= '0;
            unique case (st)
                ST_IDLE: begin
                    if (start_req) begin
                        st          <= ST_WAIT;
                        pins.conv_n <= 1'b0;
                        pins.busy   <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    // ready edge takes precedence over an expiring window
                    if (d_rise) begin
                        st <= ST_LO;
                    end else if (rt_last) begin
                        st          <= ST_IDLE;
                        pins.conv_n <= 1'b1;
                        pins.busy   <= 1'b0;
                        evt.timeout <= 1'b1;
                    end
                end
                ST_LO: begin
                    if (ph_last) begin
                        st        <= ST_HI;
                        pins.sclk <= 1'b1;
                    end
                end
                ST_HI: begin
                    if (ph_last) begin
                        pins.sclk <= 1'b0;
                        st        <= sh_last ? ST_DONE : ST_LO;
                    end
                end
                ST_DONE: begin
                    st          <= ST_IDLE;
                    pins.conv_n <= 1'b1;
                    pins.busy   <= 1'b0;
                    if (sh_word[NBITS-1]) begin
                        evt.ok <= 1'b1;
                        res_q  <= sh_word[RW-1:0];
                    end else begin
                        evt.bad_marker <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign conv_n      = pins.conv_n;
    assign sclk        = pins.sclk;
    assign busy        = pins.busy;
    assign res_data    = res_q;
    assign res_valid   = evt.ok;
    assign marker_err  = evt.bad_marker;
    assign timeout_err = evt.timeout;
endmodule

// File: rtl/rdout_chk.sv
module rdout_chk
    import rdout_pkg::*;
#(
    parameter int HI_W  = 2,
    parameter int NBITS = 16
) (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic conv_n,
    input logic sclk,
    input logic busy,
    input logic res_valid,
    input logic marker_err,
    input logic timeout_err
);
    localparam int HRW = cnt_w(HI_W) + 1;
    localparam int PCW = cnt_w(NBITS) + 1;

    logic           sclk_d;
    logic [HRW-1:0] hi_run;
    logic [PCW-1:0] pcnt;
    logic           any_evt;

    assign any_evt = res_valid | marker_err | timeout_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            hi_run <= '0;
            pcnt   <= '0;
        end else begin
            sclk_d <= sclk;
            if (!sclk)             hi_run <= '0;
            else if (hi_run != '1) hi_run <= hi_run + 1'b1;
            if (conv_n)                         pcnt <= '0;
            else if (sclk_d && !sclk && pcnt != '1) pcnt <= pcnt + 1'b1;
        end
    end

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        conv_n |-> !sclk);

    p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_n) |-> ($past(start_req) && !$past(busy)));

    p_hi_width_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_run == HRW'(HI_W)));

    p_pulse_count_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid || marker_err) |-> (pcnt == PCW'(NBITS)));

    p_close_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid || marker_err) |-> (conv_n && !busy && $past(busy)));

    p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (conv_n && !busy && $past(busy) && pcnt == '0));

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, marker_err, timeout_err}));

    p_single_r9: assert property (@(posedge clk) disable iff (rst)
        any_evt |=> !any_evt);
endmodule

bind adc_readout_master rdout_chk #(.HI_W(HI_W), .NBITS(NBITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .conv_n     (conv_n),
    .sclk       (sclk),
    .busy       (busy),
    .res_valid  (res_valid),
    .marker_err (marker_err),
    .timeout_err(timeout_err)
);

// File: tb/sim_adc_readout_master.sv
module sim_adc_readout_master;
    localparam int HI  = 2;
    localparam int LO  = 2;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        sdat = 1'b0;
    logic        conv_n, sclk, busy, res_valid, marker_err, timeout_err;
    logic [14:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [14:0] held_res = '0;

    // monitor state
    int  mon_pulses, mon_bad_hi, mon_bad_lo, mon_early, mon_idle_clk;
    int  hi_len, lo_len;
    bit  seen_fall, rdy_given;
    logic sclk_q = 1'b0;

    always #2 clk = ~clk;

    adc_readout_master #(.HI_W(HI), .LO_W(LO), .TMO(TMO), .NBITS(16), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .sdat_in    (sdat),
        .conv_n     (conv_n),
        .sclk       (sclk),
        .busy       (busy),
        .res_data   (res_data),
        .res_valid  (res_valid),
        .marker_err (marker_err),
        .timeout_err(timeout_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (conv_n && sclk) mon_idle_clk++;
            if (sclk && !sclk_q) begin
                mon_pulses++;
                if (seen_fall && lo_len != LO) mon_bad_lo++;
                if (!rdy_given) mon_early++;
                hi_len = 1;
            end else if (sclk) begin
                hi_len++;
            end
            if (!sclk && sclk_q) begin
                if (hi_len != HI) mon_bad_hi++;
                seen_fall = 1;
                lo_len = 1;
            end else if (!sclk) begin
                lo_len++;
            end
        end
        sclk_q = sclk;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [14:0] exp_res(input logic [14:0] v, input bit good, input logic [14:0] prev);
        return good ? v : prev;
    endfunction

    function automatic int exp_low_cycles(input int rise_dly);
        // rise reaches the state machine in wait clock rise_dly+3
        return (rise_dly + 3 <= TMO) ? -1 : TMO;
    endfunction

    task automatic mon_clear();
        @(posedge clk);
        mon_pulses = 0; mon_bad_hi = 0; mon_bad_lo = 0; mon_early = 0;
        hi_len = 0; lo_len = 0; seen_fall = 0; rdy_given = 0;
    endtask

    task automatic issue_start();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check("R2", "conv_n after accept", 32'(conv_n), 32'd0);
        check("R2", "busy after accept", 32'(busy), 32'd1);
        sdat = 1'b0;
    endtask

    task automatic run_ok(input logic [14:0] v, input bit good, input int dly, input bit poke);
        logic ls;
        int   guard;
        logic [14:0] want;
        mon_clear();
        issue_start();
        if (poke) begin
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        repeat (dly) @(negedge clk);
        sdat = 1'b1;
        rdy_given = 1;
        if (!good) begin
            repeat (2) @(negedge clk);
            sdat = 1'b0;
        end
        for (int i = 14; i >= 0; i--) begin
            ls = sclk;
            guard = 0;
            forever begin
                @(negedge clk);
                guard++;
                if ((ls && !sclk) || guard > 200) break;
                ls = sclk;
            end
            sdat = v[i];
        end
        guard = 0;
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        sdat = 1'b0;
        want = exp_res(v, good, held_res);
        held_res = want;
        check("R6", "res_valid at close", 32'(res_valid), 32'(good));
        check("R7", "marker_err at close", 32'(marker_err), 32'(!good));
        check("R9", "timeout_err at close", 32'(timeout_err), 32'd0);
        check("R5", "res_data", 32'(res_data), 32'(want));
        check("R6", "conv_n at close", 32'(conv_n), 32'd1);
        check("R4", "pulse count", 32'(mon_pulses), 32'd16);
        check("R4", "high width errors", 32'(mon_bad_hi), 32'd0);
        check("R4", "low width errors", 32'(mon_bad_lo), 32'd0);
        check("R3", "clock before ready", 32'(mon_early), 32'd0);
        @(negedge clk);
        check("R9", "pulse length", 32'(res_valid | marker_err), 32'd0);
        if (poke) begin
            repeat (4) @(negedge clk);
            check("R2", "no restart conv_n", 32'(conv_n), 32'd1);
            check("R2", "no restart busy", 32'(busy), 32'd0);
        end
    endtask

    task automatic run_timeout(input int rise_at);
        int lowc;
        mon_clear();
        issue_start();
        lowc = 1;
        while (!conv_n && lowc < 4 * TMO) begin
            @(negedge clk);
            if (!conv_n) lowc++;
            if (lowc == rise_at + 1) sdat = 1'b1;
        end
        check("R8", "low clocks before giving up", 32'(lowc), 32'(exp_low_cycles(rise_at)));
        check("R8", "timeout_err", 32'(timeout_err), 32'd1);
        check("R8", "busy after timeout", 32'(busy), 32'd0);
        check("R9", "res_valid on timeout", 32'(res_valid | marker_err), 32'd0);
        check("R8", "pulses on timeout", 32'(mon_pulses), 32'd0);
        check("R8", "res_data kept", 32'(res_data), 32'(held_res));
        sdat = 1'b0;
        @(negedge clk);
        check("R9", "timeout pulse length", 32'(timeout_err), 32'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        check("R1", "conv_n reset", 32'(conv_n), 32'd1);
        check("R1", "sclk reset", 32'(sclk), 32'd0);
        check("R1", "busy reset", 32'(busy), 32'd0);
        check("R1", "events reset", 32'({res_valid, marker_err, timeout_err}), 32'd0);
        check("R1", "res_data reset", 32'(res_data), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        run_ok(15'h7FFF, 1'b1, 1, 1'b0);
        run_ok(15'h0000, 1'b1, 3, 1'b0);
        run_ok(15'h5555, 1'b1, 7, 1'b0);
        run_ok(15'h1234, 1'b0, 5, 1'b0);      // R7 bad marker keeps old data
        run_ok(15'h4321, 1'b1, 4, 1'b1);      // R2 start while busy
        run_ok(15'h2AAA, 1'b1, TMO - 3, 1'b0); // R8 rise in last window clock wins
        run_timeout(TMO - 2);                  // R8 rise one clock too late
        run_timeout(100000);                   // R8 no rise at all
        run_ok(15'h0F0F, 1'b1, 2, 1'b0);
        for (int k = 0; k < 14; k++) begin
            logic [14:0] v;
            bit good;
            int d;
            v = 15'($urandom);
            good = ($urandom % 5) != 0;
            d = 1 + int'($urandom % 40);
            run_ok(v, good, d, ($urandom % 4) == 0);
        end
        check("R3", "clock while conv_n high", 32'(mon_idle_clk), 32'd0);
        summary();
        $finish;
    end
endmodule